// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block merges the five interrupt sources of a 16550-style serial port into one interrupt request line and an identification byte that the host reads to learn which source to service. It holds the 4-bit interrupt-enable register and a sticky transmit-empty pending flag. The remaining source conditions arrive as levels from the surrounding port logic: line-status errors, data ready, receive FIFO fill and trigger level, character timeout, and modem-status deltas.

The host bus decoder supplies three strobes. One writes the enable register. One marks a read of the identification byte. One marks a write to the transmit holding register. The transmit datapath raises a one-cycle event when its holding register empties. Both outputs are registered. After a clock edge they show the result of the inputs and strobes sampled at that edge.

Top module: `uart_intr_ident`

## Requirements
- R1: A synchronous reset drives the identification byte to 0x01 and the interrupt line low, and clears all four enable bits. While the enables are zero, no source raises an interrupt.
- R2: When several sources are active, the identification reports the highest one. From highest to lowest the order is: line-status error, character timeout, received data, transmit-empty, modem status.
- R3: The identification codes in bits 3:0 are 0x6 (line status), 0xC (timeout), 0x4 (received data), 0x2 (transmit-empty), 0x0 (modem status) and 0x1 (nothing pending).
- R4: A line-status interrupt requires enable bit 2 and at least one of the four error inputs (overrun, parity, framing, break). Each error bit alone is sufficient.
- R5: The timeout interrupt and the received-data interrupt both require enable bit 0.
- R6: With FIFOs on, received data is reported only when data is ready and the FIFO count is greater than or equal to the trigger level. With FIFOs off, it is reported whenever data is ready.
- R7: A transmit-empty event sets the pending flag. A read of the identification byte clears the flag only if that byte currently shows code 0x2. A read while another code is shown leaves the flag intact.
- R8: An enable write that changes bit 1 sets the pending flag if the new bit is 1 and the holding-empty level is 1, and clears it otherwise. An enable write that leaves bit 1 unchanged does not touch the flag. This rule takes precedence over every other update in the same cycle.
- R9: A write to the transmit holding register clears the pending flag, even when a transmit-empty event arrives in the same cycle.
- R10: A modem-status interrupt (code 0x0) requires enable bit 3 and any of the four delta inputs. It raises the interrupt line.
- R11: Bits 7:6 of the identification byte read 11 when FIFOs are on and 00 when they are off. Bits 5:4 read 0. The interrupt line is high exactly when the code is not 0x1.
- R12: Both outputs are registered. After each clock edge they reflect the inputs, the strobes and the enable and pending state sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ien_wr | input | 1 | Write strobe for the enable register |
| ien_wdata | input | 4 | Enable value: bit0 received data/timeout, bit1 transmit-empty, bit2 line status, bit3 modem status |
| iid_rd | input | 1 | Strobe marking a host read of the identification byte |
| thr_wr | input | 1 | Strobe marking a host write to the transmit holding register |
| thre_evt | input | 1 | One-cycle event: holding register became empty |
| thre_lvl | input | 1 | Current holding-empty level |
| fifo_on | input | 1 | FIFOs enabled |
| lsr_err | input | 4 | Overrun, parity, framing and break error flags |
| rx_ready | input | 1 | Receive data ready |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| tmo_pend | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem-status delta flags |
| irq | output | 1 | Interrupt request line |
| iid | output | 8 | Identification byte |

## Verification
The hardest condition to reach is a pending transmit-empty flag that stays hidden beneath a higher-priority source while the host reads the identification byte. The stimulus first sets the flag and then raises data ready, so the byte shows 0x4. It issues a read in that state and only then removes data ready. The expected 0x2 shows that the flag survived the read. A second difficult area is a cycle where an enable write, a holding-register write and an empty event all coincide. The bench drives these strobes together in one cycle to confirm the precedence order.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 5;

    // Priority levels: index 0 is the most urgent.
    localparam int LVL_LINE  = 0;
    localparam int LVL_TMO   = 1;
    localparam int LVL_RXD   = 2;
    localparam int LVL_THRE  = 3;
    localparam int LVL_MODEM = 4;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_THRE    = 4'h2,
        IID_RXD     = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_e;

    // Enable register layout, MSB first.
    typedef struct packed {
        logic modem;
        logic line;
        logic thre;
        logic rxd;
    } ien_t;

    function automatic iid_e level_code(input int lvl);
        case (lvl)
            LVL_LINE:  return IID_LINE;
            LVL_TMO:   return IID_TIMEOUT;
            LVL_RXD:   return IID_RXD;
            LVL_THRE:  return IID_THRE;
            LVL_MODEM: return IID_MODEM;
            default:   return IID_NONE;
        endcase
    endfunction

    function automatic logic [7:0] pack_iid(input logic fifo_en, input iid_e code);
        return {{2{fifo_en}}, 2'b00, code};
    endfunction

endpackage

// File: rtl/uart_irq_src_qual.sv
module uart_irq_src_qual
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  ien_t                 ien,
    input  logic [3:0]           lsr_err,
    input  logic                 rx_ready,
    input  logic                 fifo_on,
    input  logic [CNT_W-1:0]     rx_count,
    input  logic [CNT_W-1:0]     rx_trig,
    input  logic                 tmo_pend,
    input  logic                 thre_pend,
    input  logic [3:0]           msr_delta,
    output logic [NUM_SRC-1:0]   req
);

    logic rx_level_met;

    always_comb begin
        rx_level_met = fifo_on ? (rx_count >= rx_trig) : 1'b1;
        req            = '0;
        req[LVL_LINE]  = ien.line  & (|lsr_err);
        req[LVL_TMO]   = ien.rxd   & tmo_pend;
        req[LVL_RXD]   = ien.rxd   & rx_ready & rx_level_met;
        req[LVL_THRE]  = ien.thre  & thre_pend;
        req[LVL_MODEM] = ien.modem & (|msr_delta);
    end

endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output iid_e               code
);

    logic [NUM_SRC-1:0] grant;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
        if (i == 0) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    always_comb begin
        code = IID_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) code = level_code(i);
        end
    end

endmodule

// File: rtl/uart_irq_thre_track.sv
module uart_irq_thre_track
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ien_wr,
    input  ien_t ien_wdata,
    input  logic iid_rd,
    input  logic shows_thre,
    input  logic thr_wr,
    input  logic thre_evt,
    input  logic thre_lvl,
    output ien_t ien_q,
    output ien_t ien_nx,
    output logic pend_q,
    output logic pend_nx
);

    logic thre_flip;

    assign thre_flip = ien_wr && (ien_wdata.thre != ien_q.thre);
    assign ien_nx    = ien_wr ? ien_wdata : ien_q;

    // Later statements win: event < holding write / id read < enable flip.
    always_comb begin
        pend_nx = pend_q;
        if (thre_evt)             pend_nx = 1'b1;
        if (thr_wr)               pend_nx = 1'b0;
        if (iid_rd && shows_thre) pend_nx = 1'b0;
        if (thre_flip)            pend_nx = ien_wdata.thre & thre_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            ien_q  <= ien_nx;
            pend_q <= pend_nx;
        end
    end

    AST_THR_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !ien_wr) |=> !pend_q);  // R9

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (iid_rd && shows_thre && !ien_wr) |=> !pend_q);  // R7

    AST_FLIP_REARM: assert property (@(posedge clk) disable iff (rst)
        (ien_wr && (ien_wdata.thre != ien_q.thre)) |=> (pend_q == $past(ien_wdata.thre & thre_lvl)));  // R8

endmodule

// File: rtl/uart_intr_ident.sv
module uart_intr_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ien_wr,
    input  logic [3:0]       ien_wdata,
    input  logic             iid_rd,
    input  logic             thr_wr,
    input  logic             thre_evt,
    input  logic             thre_lvl,
    input  logic             fifo_on,
    input  logic [3:0]       lsr_err,
    input  logic             rx_ready,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             tmo_pend,
    input  logic [3:0]       msr_delta,
    output logic             irq,
    output logic [7:0]       iid
);

    ien_t               ien_q;
    ien_t               ien_nx;
    logic               pend_q;
    logic               pend_nx;
    logic [NUM_SRC-1:0] req;
    iid_e               code_nx;
    logic               shows_thre;

    assign shows_thre = (iid[3:0] == IID_THRE);

    uart_irq_thre_track u_track (
        .clk        (clk),
        .rst        (rst),
        .ien_wr     (ien_wr),
        .ien_wdata  (ien_t'(ien_wdata)),
        .iid_rd     (iid_rd),
        .shows_thre (shows_thre),
        .thr_wr     (thr_wr),
        .thre_evt   (thre_evt),
        .thre_lvl   (thre_lvl),
        .ien_q      (ien_q),
        .ien_nx     (ien_nx),
        .pend_q     (pend_q),
        .pend_nx    (pend_nx)
    );

    uart_irq_src_qual #(.CNT_W(CNT_W)) u_qual (
        .ien       (ien_nx),
        .lsr_err   (lsr_err),
        .rx_ready  (rx_ready),
        .fifo_on   (fifo_on),
        .rx_count  (rx_count),
        .rx_trig   (rx_trig),
        .tmo_pend  (tmo_pend),
        .thre_pend (pend_nx),
        .msr_delta (msr_delta),
        .req       (req)
    );

    uart_irq_prio_enc u_prio (
        .req  (req),
        .code (code_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            iid <= pack_iid(1'b0, IID_NONE);
            irq <= 1'b0;
        end else begin
            iid <= pack_iid(fifo_on, code_nx);
            irq <= (code_nx != IID_NONE);
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (iid == 8'h01 && !irq));  // R1

    AST_IRQ_FOLLOWS_CODE: assert property (@(posedge clk) disable iff (rst)
        irq == (iid[3:0] != 4'h1));  // R11

    AST_FIFO_MARK: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (iid[7:6] == {2{$past(fifo_on)}} && iid[5:4] == 2'b00));  // R11

    AST_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ien_q.line && $past(|lsr_err)) |-> (iid[3:0] == 4'h6));  // R2

    AST_RXEN_GATE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ien_q.rxd) |-> (iid[3:0] != 4'hC && iid[3:0] != 4'h4));  // R5

    AST_PEND_UNDER_EN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pend_q && ien_q.thre && !ien_q.line && !ien_q.rxd) |-> (iid[3:0] == 4'h2));  // R7

endmodule

// File: tb/uart_intr_ident_tb.sv
module uart_intr_ident_tb;

    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ien_wr = 1'b0;
    logic [3:0]       ien_wdata = '0;
    logic             iid_rd = 1'b0;
    logic             thr_wr = 1'b0;
    logic             thre_evt = 1'b0;
    logic             thre_lvl = 1'b0;
    logic             fifo_on = 1'b0;
    logic [3:0]       lsr_err = '0;
    logic             rx_ready = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [CNT_W-1:0] rx_trig = '0;
    logic             tmo_pend = 1'b0;
    logic [3:0]       msr_delta = '0;
    logic             irq;
    logic [7:0]       iid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    uart_intr_ident #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .iid_rd(iid_rd), .thr_wr(thr_wr), .thre_evt(thre_evt), .thre_lvl(thre_lvl),
        .fifo_on(fifo_on), .lsr_err(lsr_err), .rx_ready(rx_ready),
        .rx_count(rx_count), .rx_trig(rx_trig), .tmo_pend(tmo_pend),
        .msr_delta(msr_delta), .irq(irq), .iid(iid)
    );

    // Monitor: compares the outputs registered at each edge.
    always begin
        @(posedge clk);
        #1;
        if (exp_q.size() != 0) begin
            logic [7:0] e;
            logic       ei;
            string      t;
            e  = exp_q.pop_front();
            t  = tag_q.pop_front();
            ei = (e[3:0] != 4'h1);
            checks++;
            if (iid !== e || irq !== ei) begin
                errors++;
                $display("FAIL %s: iid=%02h irq=%0b expected iid=%02h irq=%0b", t, iid, irq, e, ei);
            end
        end
    end

    // Driver: queue the expected result for the coming edge, then drop the strobes.
    task automatic tick(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        ien_wr   = 1'b0;
        iid_rd   = 1'b0;
        thr_wr   = 1'b0;
        thre_evt = 1'b0;
    endtask

    task automatic wr_ien(input logic [3:0] v);
        ien_wr    = 1'b1;
        ien_wdata = v;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        tick(8'h01, "R1 reset state");
        rst = 1'b0;
        lsr_err = 4'h1; rx_ready = 1'b1; msr_delta = 4'h1; tmo_pend = 1'b1;
        tick(8'h01, "R1 sources ignored with enables zero");
        lsr_err = '0; rx_ready = 1'b0; msr_delta = '0; tmo_pend = 1'b0;

        thre_lvl = 1'b1;
        wr_ien(4'b1111);
        tick(8'h02, "R8 R12 enable rise with empty holding arms flag");
        tick(8'h02, "R7 flag persists");
        iid_rd = 1'b1;
        tick(8'h01, "R7 read showing 0x2 clears flag");
        tick(8'h01, "R7 flag stays clear");
        thre_evt = 1'b1;
        tick(8'h02, "R7 empty event sets flag");
        thr_wr = 1'b1;
        tick(8'h01, "R9 holding write clears flag");
        thre_evt = 1'b1;
        tick(8'h02, "R7 empty event sets flag again");
        rx_ready = 1'b1;
        tick(8'h04, "R2 R6 received data over transmit-empty, FIFOs off");
        iid_rd = 1'b1;
        tick(8'h04, "R7 read showing 0x4 keeps flag");
        rx_ready = 1'b0;
        tick(8'h02, "R7 hidden flag exposed after read");
        tmo_pend = 1'b1; rx_ready = 1'b1;
        tick(8'h0C, "R2 R3 timeout over received data");
        for (int i = 0; i < 4; i++) begin
            lsr_err = 4'b0001 << i;
            tick(8'h06, $sformatf("R4 line error bit %0d wins", i));
        end
        lsr_err = '0;
        tick(8'h0C, "R2 timeout after line cleared");
        tmo_pend = 1'b0;
        tick(8'h04, "R3 received data code");
        rx_ready = 1'b0;
        tick(8'h02, "R3 transmit-empty code");
        msr_delta = 4'b0100;
        tick(8'h02, "R2 transmit-empty over modem");
        thr_wr = 1'b1;
        tick(8'h00, "R10 modem status code raises irq");
        msr_delta = '0;
        tick(8'h01, "R10 no delta no interrupt");

        wr_ien(4'b1110); tmo_pend = 1'b1; rx_ready = 1'b1;
        tick(8'h01, "R5 timeout and data gated by bit 0");
        thre_evt = 1'b1;
        tick(8'h02, "R7 event with bit 0 off");
        thre_lvl = 1'b0;
        wr_ien(4'b1110);
        tick(8'h02, "R8 write without bit 1 change keeps flag");
        wr_ien(4'b1100);
        tick(8'h01, "R8 bit 1 fall clears flag");
        wr_ien(4'b1110);
        tick(8'h01, "R8 bit 1 rise with holding busy stays clear");
        tmo_pend = 1'b0; rx_ready = 1'b0;
        wr_ien(4'b1111);
        tick(8'h01, "R8 bit 0 only change");

        fifo_on = 1'b1;
        tick(8'hC1, "R11 FIFO mark with no interrupt");
        rx_ready = 1'b1; rx_trig = 5'd4; rx_count = 5'd3;
        tick(8'hC1, "R6 count below trigger");
        rx_count = 5'd4;
        tick(8'hC4, "R6 count equal to trigger");
        rx_count = 5'd5;
        tick(8'hC4, "R6 count above trigger");
        fifo_on = 1'b0; rx_count = 5'd0;
        tick(8'h04, "R6 R11 FIFOs off, ready alone suffices");
        rx_ready = 1'b0;
        thre_evt = 1'b1; thr_wr = 1'b1;
        tick(8'h01, "R9 holding write beats empty event");
        wr_ien(4'b1101);
        tick(8'h01, "R8 bit 1 fall");
        thre_lvl = 1'b1; thr_wr = 1'b1;
        wr_ien(4'b1111);
        tick(8'h02, "R8 enable rise beats holding write");
        iid_rd = 1'b1;
        tick(8'h01, "R7 read clears flag");

        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule